// File: doc/BRIEF.md
# Command-Style Bit Set/Clear Register Bank

This block holds five 32-bit control registers that software updates without any read-modify-write sequence. Each register is split into four byte lanes. In each lane, bit 7 is a polarity bit and bits 6:0 are a selection mask. A write forces every selected bit in that lane to the polarity value and leaves every other bit alone. The polarity bit itself is never stored. Each register has its own mask of implemented bits, and only those bits hold state.

The bank sits behind a simple synchronous slave port with a byte address, write data, byte strobes, a write enable and a read enable. Read data is registered. The full contents of every register are also driven out in parallel to the logic they control. Five bits of the run-control register are demand bits: four transmit-queue kicks and one receive-queue kick. Each demand bit clears itself one cycle after it is set, so it gives a single-cycle pulse on a dedicated output.

Top module: `csr_cmd_bank`

## Requirements
- R1: While rst_ni is low, every register, rdata_o and every kick output is 0.
- R2: A write to a decoded address, with be_i[k] high and bit 8k+7 of wdata_i equal to 1, sets to 1 every implemented register bit 8k+j (j in 0..6) for which wdata_i[8k+j] is 1.
- R3: The same write with bit 8k+7 equal to 0 clears those selected bits to 0. Unselected bits keep their value.
- R4: The lanes act independently. A lane whose be_i bit is low is left unchanged, even when the other lanes of the same write change.
- R5: With we_i low, no register changes. The only exception is the self-clearing of demand bits.
- R6: Register bits 7, 15, 23, 31 and every bit outside the implemented mask always read as 0. The masks are 0x1F7F7F1F (offset 0x40), 0x000F0F7F (0x48), 0x3F7F3F7F (0x50), 0x203C7E07 (0x54) and 0x0000001B (0x64).
- R7: The registers decode at byte addresses 0x40 (irq_en_o), 0x48 (run_ctl_o), 0x50 (cfg_a_o), 0x54 (cfg_b_o) and 0x64 (wake_ctl_o). Each register appears on its own output port.
- R8: A write to any other address changes nothing. A read of any other address returns 0.
- R9: When re_i is high, rdata_o in the next cycle holds the register contents as they were before any write in the same cycle. When re_i is low, rdata_o in the next cycle is 0.
- R10: In the 0x48 register, bits 8..11 (transmit queues 0..3, on tx_kick_o[3:0]) and bit 16 (receive queue, on rx_kick_o) are demand bits. A demand bit that is set reads as 1 for exactly one cycle and then clears itself.
- R11: If a write sets a demand bit in the same cycle that the bit would clear itself, the write wins and the bit stays 1 for one more cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 32 | Write data: four lanes, each with a polarity bit and a select mask |
| be_i | input | 4 | Byte-lane strobes |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Registered read data |
| irq_en_o | output | 32 | Contents of the register at 0x40 |
| run_ctl_o | output | 32 | Contents of the register at 0x48 |
| cfg_a_o | output | 32 | Contents of the register at 0x50 |
| cfg_b_o | output | 32 | Contents of the register at 0x54 |
| wake_ctl_o | output | 32 | Contents of the register at 0x64 |
| tx_kick_o | output | 4 | One-cycle transmit-queue demand pulses |
| rx_kick_o | output | 1 | One-cycle receive-queue demand pulse |

## Verification
The assertions assume that the bus inputs are driven to known values in every cycle after reset. They also assume that a write and a read in the same cycle target a single address, which is the only form the port allows. The bench drives all inputs away from the rising edge and keeps strobes and data defined at all times. It uses only aligned addresses, and it leaves the bus idle between transactions except in the deliberate same-cycle read/write and back-to-back demand tests. The hold properties exclude demand bits, so the self-clear never conflicts with the rule that a lane without a strobe stays unchanged.

// File: rtl/csr_cmd_pkg.sv
package csr_cmd_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned NUM_LANES = DATA_W / LANE_W;
  localparam int unsigned SEL_W     = LANE_W - 1;
  localparam int unsigned NUM_REGS  = 5;
  localparam int unsigned ADDR_W    = 9;
  localparam int unsigned NUM_TX    = 4;
  localparam int unsigned TX_LSB    = 8;
  localparam int unsigned RX_BIT    = 16;

  localparam int unsigned IDX_IRQ  = 0;
  localparam int unsigned IDX_RUN  = 1;
  localparam int unsigned IDX_CFGA = 2;
  localparam int unsigned IDX_CFGB = 3;
  localparam int unsigned IDX_WAKE = 4;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  function automatic addr_t reg_offset(input int unsigned idx);
    case (idx)
      IDX_IRQ:  return addr_t'(9'h040);
      IDX_RUN:  return addr_t'(9'h048);
      IDX_CFGA: return addr_t'(9'h050);
      IDX_CFGB: return addr_t'(9'h054);
      default:  return addr_t'(9'h064);
    endcase
  endfunction

  function automatic word_t reg_mask(input int unsigned idx);
    case (idx)
      IDX_IRQ:  return 32'h1F7F_7F1F;
      IDX_RUN:  return 32'h000F_0F7F;
      IDX_CFGA: return 32'h3F7F_3F7F;
      IDX_CFGB: return 32'h203C_7E07;
      default:  return 32'h0000_001B;
    endcase
  endfunction

  function automatic word_t reg_self_clr(input int unsigned idx);
    word_t m;
    m = '0;
    if (idx == IDX_RUN) begin
      for (int unsigned i = 0; i < NUM_TX; i++) m[TX_LSB+i] = 1'b1;
      m[RX_BIT] = 1'b1;
    end
    return m;
  endfunction

  // polarity-bit positions, top bit of every lane
  function automatic word_t val_positions();
    word_t m;
    m = '0;
    for (int unsigned k = 0; k < NUM_LANES; k++) m[k*LANE_W+SEL_W] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/csr_lane_upd.sv
module csr_lane_upd
  import csr_cmd_pkg::*;
(
  input  logic [SEL_W-1:0]  cur_i,
  input  logic [LANE_W-1:0] wbyte_i,
  input  logic              en_i,
  input  logic [SEL_W-1:0]  mask_i,
  output logic [SEL_W-1:0]  nxt_o
);
  logic [SEL_W-1:0] sel;
  logic             pol;

  assign sel = wbyte_i[SEL_W-1:0] & mask_i;
  assign pol = wbyte_i[LANE_W-1];

  always_comb begin
    nxt_o = cur_i & mask_i;
    if (en_i) begin
      if (pol) nxt_o = (cur_i | sel) & mask_i;
      else     nxt_o = cur_i & ~sel & mask_i;
    end
  end
endmodule

// File: rtl/csr_cmd_reg.sv
module csr_cmd_reg
  import csr_cmd_pkg::*;
#(
  parameter word_t IMPL_MASK = '1,
  parameter word_t SELF_CLR  = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [NUM_LANES-1:0] be_i,
  input  word_t                wdata_i,
  output word_t                q_o
);
  localparam word_t HOLD_MASK = ~SELF_CLR;

  word_t q, base, nxt;

  // demand bits drop before the write is applied, so a write wins
  assign base = q & HOLD_MASK;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    csr_lane_upd u_lane (
      .cur_i   (base[k*LANE_W +: SEL_W]),
      .wbyte_i (wdata_i[k*LANE_W +: LANE_W]),
      .en_i    (wr_en_i & be_i[k]),
      .mask_i  (IMPL_MASK[k*LANE_W +: SEL_W]),
      .nxt_o   (nxt[k*LANE_W +: SEL_W])
    );
    assign nxt[k*LANE_W+SEL_W] = 1'b0;

    p_lane_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && be_i[k] && wdata_i[k*LANE_W+SEL_W])
      |=> ((q[k*LANE_W +: SEL_W] & $past(wdata_i[k*LANE_W +: SEL_W]) & IMPL_MASK[k*LANE_W +: SEL_W])
           == ($past(wdata_i[k*LANE_W +: SEL_W]) & IMPL_MASK[k*LANE_W +: SEL_W])));

    p_lane_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && be_i[k] && !wdata_i[k*LANE_W+SEL_W])
      |=> ((q[k*LANE_W +: SEL_W] & $past(wdata_i[k*LANE_W +: SEL_W])) == '0));

    p_lane_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(wr_en_i && be_i[k]))
      |=> $stable(q[k*LANE_W +: SEL_W] & HOLD_MASK[k*LANE_W +: SEL_W]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o = q;

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(q & HOLD_MASK));

  p_unimpl_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q & ~IMPL_MASK) == '0);

  if (SELF_CLR != '0) begin : g_self_clr_chk
    p_self_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (((q & SELF_CLR) != '0) && !wr_en_i) |=> ((q & SELF_CLR) == '0));
  end
endmodule

// File: rtl/csr_rd_mux.sv
module csr_rd_mux
  import csr_cmd_pkg::*;
#(
  parameter int unsigned N = NUM_REGS
) (
  input  logic [N-1:0][DATA_W-1:0] regs_i,
  input  logic [N-1:0]             hit_i,
  output word_t                    rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int unsigned i = 0; i < N; i++)
      rdata_o = rdata_o | (regs_i[i] & {DATA_W{hit_i[i]}});
  end
endmodule

// File: rtl/csr_cmd_bank.sv
module csr_cmd_bank
  import csr_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [8:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic [3:0]  be_i,
  input  logic        we_i,
  input  logic        re_i,
  output logic [31:0] rdata_o,
  output logic [31:0] irq_en_o,
  output logic [31:0] run_ctl_o,
  output logic [31:0] cfg_a_o,
  output logic [31:0] cfg_b_o,
  output logic [31:0] wake_ctl_o,
  output logic [3:0]  tx_kick_o,
  output logic        rx_kick_o
);
  localparam word_t VAL_POS = val_positions();

  logic [NUM_REGS-1:0]             hit;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  word_t                           rd_word, rdata_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign hit[i] = (addr_i == reg_offset(i));

    csr_cmd_reg #(
      .IMPL_MASK (reg_mask(i)),
      .SELF_CLR  (reg_self_clr(i))
    ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (we_i & hit[i]),
      .be_i    (be_i),
      .wdata_i (wdata_i),
      .q_o     (regs_q[i])
    );
  end

  csr_rd_mux #(.N(NUM_REGS)) u_rd_mux (
    .regs_i  (regs_q),
    .hit_i   (hit),
    .rdata_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_word;
    else           rdata_q <= '0;
  end

  assign rdata_o    = rdata_q;
  assign irq_en_o   = regs_q[IDX_IRQ];
  assign run_ctl_o  = regs_q[IDX_RUN];
  assign cfg_a_o    = regs_q[IDX_CFGA];
  assign cfg_b_o    = regs_q[IDX_CFGB];
  assign wake_ctl_o = regs_q[IDX_WAKE];
  assign tx_kick_o  = regs_q[IDX_RUN][TX_LSB +: NUM_TX];
  assign rx_kick_o  = regs_q[IDX_RUN][RX_BIT];

  p_hit_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));

  p_rd_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (hit == '0)) |=> (rdata_o == '0));

  p_miss_no_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |=> ($stable(irq_en_o) && $stable(cfg_a_o) && $stable(cfg_b_o)
                     && $stable(wake_ctl_o)));

  p_rd_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == '0));

  p_rd_old_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && hit[IDX_CFGA]) |=> (rdata_o == $past(cfg_a_o)));

  p_val_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & VAL_POS) == '0);
endmodule

// File: tb/csr_cmd_bank_tb.sv
module csr_cmd_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VECS   = 14;

  typedef struct packed {
    logic [8:0]  addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  // write, then read back the same address
  localparam vec_t VECS [NUM_VECS] = '{
    '{9'h040, 4'hF, 32'hFFFF_FFFF, 32'h1F7F_7F1F},  // R2 R6
    '{9'h040, 4'h1, 32'h0000_001A, 32'h1F7F_7F05},  // R3
    '{9'h040, 4'h2, 32'h0000_0100, 32'h1F7F_7E05},  // R3 lane1
    '{9'h040, 4'h0, 32'h0000_0000, 32'h1F7F_7E05},  // R4 no strobe
    '{9'h040, 4'h8, 32'h1F00_0000, 32'h007F_7E05},  // R4 lane3 only
    '{9'h050, 4'hF, 32'h9A9A_9A9A, 32'h1A1A_1A1A},  // R2 all lanes
    '{9'h050, 4'h4, 32'h00FF_0000, 32'h1A7F_1A1A},  // R4
    '{9'h050, 4'h1, 32'hFFFF_FFFF, 32'h1A7F_1A7F},  // R4
    '{9'h064, 4'hF, 32'hFFFF_FFFF, 32'h0000_001B},  // R6 mask
    '{9'h064, 4'h1, 32'h0000_0001, 32'h0000_001A},  // R3
    '{9'h054, 4'hF, 32'hFFFF_FFFF, 32'h203C_7E07},  // R6 mask
    '{9'h054, 4'h2, 32'h0000_7F00, 32'h203C_0007},  // R3
    '{9'h048, 4'h1, 32'h0000_0083, 32'h0000_0003},  // R7
    '{9'h060, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000}   // R8 undecoded
  };

  logic        clk;
  logic        rst_ni;
  logic [8:0]  addr;
  logic [31:0] wdata;
  logic [3:0]  be;
  logic        we, re;
  logic [31:0] rdata, irq_en, run_ctl, cfg_a, cfg_b, wake_ctl;
  logic [3:0]  tx_kick;
  logic        rx_kick;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  csr_cmd_bank dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .be_i       (be),
    .we_i       (we),
    .re_i       (re),
    .rdata_o    (rdata),
    .irq_en_o   (irq_en),
    .run_ctl_o  (run_ctl),
    .cfg_a_o    (cfg_a),
    .cfg_b_o    (cfg_b),
    .wake_ctl_o (wake_ctl),
    .tx_kick_o  (tx_kick),
    .rx_kick_o  (rx_kick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; be = '0; wdata = '0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_chk++; n_err++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    rst_ni = 1'b0; addr = '0; wdata = '0; be = '0; we = 1'b0; re = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq_en", irq_en, 32'h0);
    chk("R1 run_ctl", run_ctl, 32'h0);
    chk("R1 cfg_a", cfg_a, 32'h0);
    chk("R1 cfg_b", cfg_b, 32'h0);
    chk("R1 wake_ctl", wake_ctl, 32'h0);
    chk("R1 kicks", {27'h0, rx_kick, tx_kick}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NUM_VECS; i++) begin
      bus_write(VECS[i].addr, VECS[i].be, VECS[i].wdata);
      bus_read(VECS[i].addr, rd);
      chk($sformatf("R2/R3/R4/R6/R8 vec%0d", i), rd, VECS[i].exp);
    end

    // R7 parallel outputs after the table
    chk("R7 irq_en_o", irq_en, 32'h007F_7E05);
    chk("R7 run_ctl_o", run_ctl, 32'h0000_0003);
    chk("R7 cfg_a_o", cfg_a, 32'h1A7F_1A7F);
    chk("R7 cfg_b_o", cfg_b, 32'h203C_0007);
    chk("R7 wake_ctl_o", wake_ctl, 32'h0000_001A);
    // R8 undecoded write left every register alone
    bus_read(9'h040, rd);
    chk("R8 irq after miss", rd, 32'h007F_7E05);

    // R5 we low with data on the bus
    @(negedge clk);
    addr = 9'h040; be = 4'hF; wdata = 32'h7F7F_7F7F; we = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 idle hold", irq_en, 32'h007F_7E05);
    be = '0; wdata = '0;

    // R9 read with same-cycle write returns old contents
    @(negedge clk);
    addr = 9'h064; be = 4'h1; wdata = 32'h0000_0081; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0; be = '0; wdata = '0;
    chk("R9 old value", rdata, 32'h0000_001A);
    chk("R9 write landed", wake_ctl, 32'h0000_001B);
    @(negedge clk);
    chk("R9 re low zero", rdata, 32'h0);

    // R10 transmit kicks 0 and 2
    bus_write(9'h048, 4'h2, 32'h0000_8500);
    chk("R10 tx pulse", {28'h0, tx_kick}, 32'h5);
    chk("R10 run bits kept", run_ctl, 32'h0000_0503);
    @(negedge clk);
    chk("R10 tx cleared", {28'h0, tx_kick}, 32'h0);
    chk("R10 run after clear", run_ctl, 32'h0000_0003);
    // R10 receive kick
    bus_write(9'h048, 4'h4, 32'h0081_0000);
    chk("R10 rx pulse", {31'h0, rx_kick}, 32'h1);
    @(negedge clk);
    chk("R10 rx cleared", {31'h0, rx_kick}, 32'h0);

    // R11 write on the self-clear cycle wins
    @(negedge clk);
    addr = 9'h048; be = 4'h2; wdata = 32'h0000_8200; we = 1'b1;
    @(negedge clk);
    chk("R11 first set", {28'h0, tx_kick}, 32'h2);
    @(negedge clk);
    we = 1'b0; be = '0; wdata = '0;
    chk("R11 write wins", {28'h0, tx_kick}, 32'h2);
    @(negedge clk);
    chk("R11 then clears", {28'h0, tx_kick}, 32'h0);

    // R1 reset mid-run
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", irq_en | cfg_a | cfg_b | wake_ctl | run_ctl, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    finish_run();
  end
endmodule